// File: doc/BRIEF.md
# Shared I2C Slave Buffer Pointers

This block holds a small byte buffer that an I2C slave byte engine and a CPU share. Each side walks the buffer with its own pair of pointers: a base pointer that software sets, and a current pointer that names the byte accessed next. The I2C side receives byte-level events from the slave engine: a start condition, a completed data byte with its direction, and the byte the master wrote. For reads it supplies the next outgoing byte.

The CPU reaches the block through a small register window. It can set both base pointers, read all four pointers, and stream bytes in or out through a data register. The I2C current pointer reloads from its base on every bus start condition. The CPU current pointer reloads whenever firmware writes the CPU base pointer. A compatibility input freezes all pointer state, so that other logic can own the buffer.

Top module: `shbuf_top`

## Requirements
- R1: After reset, all four pointers read 0.
- R2: On a cycle with `i2c_start_i` high, the I2C current pointer takes the I2C base pointer value. Writing the I2C base pointer alone leaves the I2C current pointer unchanged.
- R3: Each cycle with `i2c_byte_done_i` high advances the I2C current pointer by one. When start and byte-done arrive in the same cycle, the start reload wins.
- R4: The I2C current pointer steps from 31 back to 0.
- R5: A completed write byte (`i2c_byte_rd_i`=0) stores `i2c_wdata_i` at the I2C current pointer. `i2c_rdata_o` always shows the byte at the I2C current pointer, so it is valid before a read byte completes.
- R6: A CPU write to register 2 (CPU base pointer) sets both the CPU base pointer and the CPU current pointer to bits [4:0] of the write data.
- R7: Each CPU read or write of register 4 (data) uses the byte at the CPU current pointer, and the pointer then advances by one, stepping from 31 to 0.
- R8: Registers 1 (I2C current pointer) and 3 (CPU current pointer) are read-only, and CPU writes to them have no effect.
- R9: While `compat_i` is high, no pointer changes: base writes, start, byte-done and data accesses leave all four pointers as they were. Buffer bytes are still read and written at the current pointers.
- R10: When the I2C side and the CPU side write the same byte in the same cycle, the I2C byte is stored.
- R11: The register map is 0 = I2C base pointer (read/write), 1 = I2C current, 2 = CPU base, 3 = CPU current, 4 = data. Pointer registers read back zero-extended 5-bit values. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_i | input | 1 | Freeze all pointer state |
| i2c_start_i | input | 1 | Start condition seen on the bus |
| i2c_byte_done_i | input | 1 | A data byte completed |
| i2c_byte_rd_i | input | 1 | Completed byte was a master read (1) or write (0) |
| i2c_wdata_i | input | 8 | Byte written by the master |
| i2c_rdata_o | output | 8 | Byte at the I2C current pointer |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_rd_i | input | 1 | CPU register read strobe |
| cpu_addr_i | input | 3 | CPU register address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data for the addressed register |

## Verification
The bench builds the block with its defaults: a 32-entry buffer of 8-bit bytes and 5-bit pointers. With so few entries, a run of three I2C bytes starting at 30 and one CPU byte at 31 reach the wrap-around within a few cycles. The run covers both pointer wraps, the start-over-byte-done priority, frozen pointers in compatibility mode, and a same-address write collision between the two sides, all observed through the register window and the I2C read byte.

// File: rtl/shbuf_pkg.sv
`timescale 1ns/1ps
package shbuf_pkg;
  typedef enum logic [2:0] {
    REG_I2C_BASE = 3'd0,
    REG_I2C_CUR  = 3'd1,
    REG_CPU_BASE = 3'd2,
    REG_CPU_CUR  = 3'd3,
    REG_DATA     = 3'd4
  } shbuf_reg_e;
endpackage

// File: rtl/shbuf_ptr_pair.sv
`timescale 1ns/1ps
// Base/current pointer pair with reload, step and wrap.
module shbuf_ptr_pair #(
  parameter int DEPTH          = 32,
  parameter int PTR_W          = 5,
  parameter bit FOLLOW_BASE_WR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             base_we_i,
  input  logic [PTR_W-1:0] base_wdata_i,
  input  logic             reload_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] base_o,
  output logic [PTR_W-1:0] cur_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] base_q, base_d, cur_q, cur_d, cur_inc;
  logic             base_en, cur_en, follow;

  generate
    if (FOLLOW_BASE_WR) begin : g_follow
      assign follow = base_we_i;
    end else begin : g_nofollow
      assign follow = 1'b0;
    end
  endgenerate

  always_comb begin
    cur_inc = (cur_q == LAST) ? '0 : cur_q + 1'b1;
    base_en = base_we_i && !hold_i;
    base_d  = base_wdata_i;
    cur_en  = !hold_i && (follow || reload_i || step_i);
    if (follow)        cur_d = base_wdata_i;
    else if (reload_i) cur_d = base_q;
    else               cur_d = cur_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;

  p_reload_from_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !hold_i && !follow) |=> (cur_q == $past(base_q)));

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reload_i && !follow && !hold_i && cur_q != LAST)
      |=> (cur_q == $past(cur_q) + 1'b1));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reload_i && !follow && !hold_i && cur_q == LAST) |=> (cur_q == '0));

  p_base_write_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (follow && !hold_i) |=> (cur_q == $past(base_wdata_i) && base_q == $past(base_wdata_i)));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(cur_q) && $stable(base_q)));
endmodule

// File: rtl/shbuf_mem.sv
`timescale 1ns/1ps
// Byte storage: two write ports (port A has priority), two read ports.
module shbuf_mem #(
  parameter int DEPTH  = 32,
  parameter int PTR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we_i,
  input  logic [PTR_W-1:0]  a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              b_we_i,
  input  logic [PTR_W-1:0]  b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic [PTR_W-1:0]  a_raddr_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic [PTR_W-1:0]  b_raddr_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic              hit_a, hit_b, ent_en;
      logic [DATA_W-1:0] ent_d;
      always_comb begin
        hit_a  = a_we_i && (a_addr_i == PTR_W'(g));
        hit_b  = b_we_i && (b_addr_i == PTR_W'(g));
        ent_en = hit_a || hit_b;
        ent_d  = hit_a ? a_wdata_i : b_wdata_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mem_q[g] <= '0;
        else if (ent_en) mem_q[g] <= ent_d;
      end
    end
  endgenerate

  assign a_rdata_o = mem_q[a_raddr_i];
  assign b_rdata_o = mem_q[b_raddr_i];

  p_port_a_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_we_i |=> (mem_q[$past(a_addr_i)] == $past(a_wdata_i)));

  p_port_a_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we_i && b_we_i && a_addr_i == b_addr_i)
      |=> (mem_q[$past(a_addr_i)] == $past(a_wdata_i)));
endmodule

// File: rtl/shbuf_regif.sv
`timescale 1ns/1ps
// CPU register decode and read mux.
module shbuf_regif
  import shbuf_pkg::*;
#(
  parameter int PTR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [2:0]        cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [PTR_W-1:0]  i2c_base_i,
  input  logic [PTR_W-1:0]  i2c_cur_i,
  input  logic [PTR_W-1:0]  cpu_base_i,
  input  logic [PTR_W-1:0]  cpu_cur_i,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              i2c_base_we_o,
  output logic              cpu_base_we_o,
  output logic              data_we_o,
  output logic              data_step_o,
  output logic [PTR_W-1:0]  base_wdata_o,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  shbuf_reg_e sel;

  always_comb begin
    sel           = shbuf_reg_e'(cpu_addr_i);
    i2c_base_we_o = cpu_wr_i && (sel == REG_I2C_BASE);
    cpu_base_we_o = cpu_wr_i && (sel == REG_CPU_BASE);
    data_we_o     = cpu_wr_i && (sel == REG_DATA);
    data_step_o   = (cpu_wr_i || cpu_rd_i) && (sel == REG_DATA);
    base_wdata_o  = cpu_wdata_i[PTR_W-1:0];
    case (sel)
      REG_I2C_BASE: cpu_rdata_o = DATA_W'(i2c_base_i);
      REG_I2C_CUR:  cpu_rdata_o = DATA_W'(i2c_cur_i);
      REG_CPU_BASE: cpu_rdata_o = DATA_W'(cpu_base_i);
      REG_CPU_CUR:  cpu_rdata_o = DATA_W'(cpu_cur_i);
      REG_DATA:     cpu_rdata_o = buf_rdata_i;
      default:      cpu_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/shbuf_top.sv
`timescale 1ns/1ps
module shbuf_top
  import shbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              compat_i,
  input  logic              i2c_start_i,
  input  logic              i2c_byte_done_i,
  input  logic              i2c_byte_rd_i,
  input  logic [DATA_W-1:0] i2c_wdata_i,
  output logic [DATA_W-1:0] i2c_rdata_o,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [2:0]        cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  i2c_base, i2c_cur, cpu_base, cpu_cur, base_wdata;
  logic              i2c_base_we, cpu_base_we, data_we, data_step, i2c_we;
  logic [DATA_W-1:0] buf_rdata;

  assign i2c_we = i2c_byte_done_i && !i2c_byte_rd_i;

  shbuf_regif #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regif (
    .cpu_wr_i      (cpu_wr_i),
    .cpu_rd_i      (cpu_rd_i),
    .cpu_addr_i    (cpu_addr_i),
    .cpu_wdata_i   (cpu_wdata_i),
    .i2c_base_i    (i2c_base),
    .i2c_cur_i     (i2c_cur),
    .cpu_base_i    (cpu_base),
    .cpu_cur_i     (cpu_cur),
    .buf_rdata_i   (buf_rdata),
    .i2c_base_we_o (i2c_base_we),
    .cpu_base_we_o (cpu_base_we),
    .data_we_o     (data_we),
    .data_step_o   (data_step),
    .base_wdata_o  (base_wdata),
    .cpu_rdata_o   (cpu_rdata_o)
  );

  shbuf_ptr_pair #(.DEPTH(DEPTH), .PTR_W(PTR_W), .FOLLOW_BASE_WR(1'b0)) u_i2c_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_i       (compat_i),
    .base_we_i    (i2c_base_we),
    .base_wdata_i (base_wdata),
    .reload_i     (i2c_start_i),
    .step_i       (i2c_byte_done_i),
    .base_o       (i2c_base),
    .cur_o        (i2c_cur)
  );

  shbuf_ptr_pair #(.DEPTH(DEPTH), .PTR_W(PTR_W), .FOLLOW_BASE_WR(1'b1)) u_cpu_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_i       (compat_i),
    .base_we_i    (cpu_base_we),
    .base_wdata_i (base_wdata),
    .reload_i     (1'b0),
    .step_i       (data_step),
    .base_o       (cpu_base),
    .cur_o        (cpu_cur)
  );

  shbuf_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_we_i    (i2c_we),
    .a_addr_i  (i2c_cur),
    .a_wdata_i (i2c_wdata_i),
    .b_we_i    (data_we),
    .b_addr_i  (cpu_cur),
    .b_wdata_i (cpu_wdata_i),
    .a_raddr_i (i2c_cur),
    .a_rdata_o (i2c_rdata_o),
    .b_raddr_i (cpu_cur),
    .b_rdata_o (buf_rdata)
  );

  p_i2c_cur_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_i && cpu_addr_i == REG_I2C_CUR && !i2c_start_i && !i2c_byte_done_i)
      |=> $stable(i2c_cur));

  p_cpu_cur_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_i && cpu_addr_i == REG_CPU_CUR) |=> $stable(cpu_cur));

  p_cpu_data_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_wr_i || cpu_rd_i) && cpu_addr_i == REG_DATA && !compat_i)
      |=> (cpu_cur == (($past(cpu_cur) == PTR_W'(DEPTH - 1)) ? '0 : $past(cpu_cur) + 1'b1)));
endmodule

// File: tb/tb_shbuf_top.sv
`timescale 1ns/1ps
module tb_shbuf_top;
  localparam int DEPTH  = 32;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, compat, i2c_start, i2c_done, i2c_rd, cpu_wr, cpu_rd;
  logic [DATA_W-1:0] i2c_wdata, i2c_rdata, cpu_wdata, cpu_rdata;
  logic [2:0] cpu_addr;

  shbuf_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .compat_i(compat),
    .i2c_start_i(i2c_start), .i2c_byte_done_i(i2c_done), .i2c_byte_rd_i(i2c_rd),
    .i2c_wdata_i(i2c_wdata), .i2c_rdata_o(i2c_rdata),
    .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata)
  );

  typedef struct {
    bit          from_i2c;
    logic [7:0]  exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  event  sample_ev;

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = it.from_i2c ? i2c_rdata : cpu_rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input bit from_i2c, input logic [7:0] exp, input string tag);
    item_t it;
    it.from_i2c = from_i2c;
    it.exp      = exp;
    it.tag      = tag;
    q.push_back(it);
    -> sample_ev;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic reg_chk(input logic [2:0] a, input logic [7:0] exp, input bit strobe,
                         input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = strobe;
    #1 expect_item(1'b0, exp, tag);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic i2c_ev(input bit st, input bit dn, input bit rd, input logic [7:0] d);
    @(negedge clk);
    i2c_start = st; i2c_done = dn; i2c_rd = rd; i2c_wdata = d;
    @(negedge clk);
    i2c_start = 1'b0; i2c_done = 1'b0;
  endtask

  task automatic i2c_chk(input logic [7:0] exp, input string tag);
    @(negedge clk);
    #1 expect_item(1'b1, exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; compat = 1'b0; i2c_start = 1'b0; i2c_done = 1'b0; i2c_rd = 1'b0;
    i2c_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) reg_chk(3'(a), 8'h00, 1'b0, "R1 pointer after reset");
    // R11 unused address and 5-bit readback
    reg_chk(3'd5, 8'h00, 1'b0, "R11 unused address");
    // R6 base write loads current
    reg_wr(3'd2, 8'hE5);
    reg_chk(3'd2, 8'h05, 1'b0, "R11 cpu base 5-bit readback");
    reg_chk(3'd3, 8'h05, 1'b0, "R6 cpu cur follows base");
    // R7 stream writes then reads
    reg_wr(3'd4, 8'hA0); reg_wr(3'd4, 8'hA1); reg_wr(3'd4, 8'hA2);
    reg_chk(3'd3, 8'h08, 1'b0, "R7 cpu cur after three writes");
    reg_wr(3'd2, 8'h05);
    reg_chk(3'd4, 8'hA0, 1'b1, "R7 data read 0");
    reg_chk(3'd4, 8'hA1, 1'b1, "R7 data read 1");
    reg_chk(3'd4, 8'hA2, 1'b1, "R7 data read 2");
    reg_chk(3'd3, 8'h08, 1'b0, "R7 cpu cur after reads");
    // R8 current pointers read-only
    reg_wr(3'd3, 8'h1F);
    reg_chk(3'd3, 8'h08, 1'b0, "R8 cpu cur write ignored");
    reg_wr(3'd1, 8'h1F);
    reg_chk(3'd1, 8'h00, 1'b0, "R8 i2c cur write ignored");
    // R2 start reload, R5 writes
    reg_wr(3'd0, 8'h0A);
    reg_chk(3'd0, 8'h0A, 1'b0, "R11 i2c base readback");
    reg_chk(3'd1, 8'h00, 1'b0, "R2 base write alone keeps i2c cur");
    i2c_ev(1'b1, 1'b0, 1'b0, 8'h00);
    reg_chk(3'd1, 8'h0A, 1'b0, "R2 start loads i2c cur");
    i2c_ev(1'b0, 1'b1, 1'b0, 8'h11);
    i2c_ev(1'b0, 1'b1, 1'b0, 8'h22);
    reg_chk(3'd1, 8'h0C, 1'b0, "R3 i2c cur after two bytes");
    reg_wr(3'd2, 8'h0A);
    reg_chk(3'd4, 8'h11, 1'b1, "R5 master byte 0 stored");
    reg_chk(3'd4, 8'h22, 1'b1, "R5 master byte 1 stored");
    // R5 read path
    reg_wr(3'd2, 8'h14);
    reg_wr(3'd4, 8'h55); reg_wr(3'd4, 8'h66);
    reg_wr(3'd0, 8'h14);
    i2c_ev(1'b1, 1'b0, 1'b0, 8'h00);
    i2c_chk(8'h55, "R5 read byte presented 0");
    i2c_ev(1'b0, 1'b1, 1'b1, 8'hEE);
    i2c_chk(8'h66, "R5 read byte presented 1");
    i2c_ev(1'b0, 1'b1, 1'b1, 8'hEE);
    reg_chk(3'd1, 8'h16, 1'b0, "R3 i2c cur after read bytes");
    reg_wr(3'd2, 8'h15);
    reg_chk(3'd4, 8'h66, 1'b1, "R5 read byte not overwritten");
    // R3 start wins over byte done
    i2c_ev(1'b1, 1'b1, 1'b1, 8'h00);
    reg_chk(3'd1, 8'h14, 1'b0, "R3 start wins over byte done");
    // R4 I2C wrap
    reg_wr(3'd0, 8'h1E);
    i2c_ev(1'b1, 1'b0, 1'b0, 8'h00);
    i2c_ev(1'b0, 1'b1, 1'b0, 8'h71);
    i2c_ev(1'b0, 1'b1, 1'b0, 8'h72);
    i2c_ev(1'b0, 1'b1, 1'b0, 8'h73);
    reg_chk(3'd1, 8'h01, 1'b0, "R4 i2c cur wrapped");
    reg_wr(3'd2, 8'h00);
    reg_chk(3'd4, 8'h73, 1'b1, "R4 byte after wrap at 0");
    reg_wr(3'd2, 8'h1F);
    reg_chk(3'd4, 8'h72, 1'b1, "R4 byte at 31");
    // R7 CPU wrap
    reg_chk(3'd3, 8'h00, 1'b0, "R7 cpu cur wrapped");
    reg_wr(3'd2, 8'h1F);
    reg_wr(3'd4, 8'h99);
    reg_chk(3'd3, 8'h00, 1'b0, "R7 cpu cur wrapped after write");
    // R9 compatibility freeze
    @(negedge clk); compat = 1'b1;
    reg_wr(3'd2, 8'h03);
    reg_chk(3'd2, 8'h1F, 1'b0, "R9 cpu base frozen");
    reg_wr(3'd4, 8'hAB);
    reg_chk(3'd3, 8'h00, 1'b0, "R9 cpu cur frozen");
    reg_wr(3'd0, 8'h07);
    reg_chk(3'd0, 8'h1E, 1'b0, "R9 i2c base frozen");
    i2c_ev(1'b1, 1'b0, 1'b0, 8'h00);
    i2c_ev(1'b0, 1'b1, 1'b0, 8'hCD);
    reg_chk(3'd1, 8'h01, 1'b0, "R9 i2c cur frozen");
    @(negedge clk); compat = 1'b0;
    reg_wr(3'd2, 8'h00);
    reg_chk(3'd4, 8'hAB, 1'b1, "R9 cpu byte stored in place");
    reg_chk(3'd4, 8'hCD, 1'b1, "R9 i2c byte stored in place");
    // R10 collision
    reg_wr(3'd2, 8'h01);
    @(negedge clk);
    cpu_addr = 3'd4; cpu_wdata = 8'h12; cpu_wr = 1'b1;
    i2c_done = 1'b1; i2c_rd = 1'b0; i2c_wdata = 8'h34;
    @(negedge clk);
    cpu_wr = 1'b0; i2c_done = 1'b0;
    reg_wr(3'd2, 8'h01);
    reg_chk(3'd4, 8'h34, 1'b1, "R10 i2c write wins");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule